// File: doc/BRIEF.md
# Armed Pulse-Capture Status Flag with Interrupt

This block watches one asynchronous input line and records, in a sticky status flag, that a complete high pulse has appeared on it. A pulse counts only if software has first set a start bit. The line must then rise and afterwards fall. The line passes through a synchroniser. A small tracking state machine then follows the edge order.

Software reaches the block through one three-bit register with simple read and write strobes. The fields are the start bit, the capture flag and an interrupt enable. The flag cannot be cleared by a plain write. Software must first read the register while the flag is 1, then write 0 to the flag field. An interrupt request output is high while the flag and the enable are both set.

The edge tracker has three states. In TRK_OFF it is disarmed. TRK_WAIT_RISE waits for a rising edge, and TRK_WAIT_FALL waits for the falling edge that completes a pulse. Its transitions are:
- arm: TRK_OFF to TRK_WAIT_RISE when the start bit is 1.
- rise: TRK_WAIT_RISE to TRK_WAIT_FALL.
- capture: TRK_WAIT_FALL to TRK_WAIT_RISE on a fall. This also raises the flag.
- disarm: any state to TRK_OFF when the start bit is 0.

The clear handshake has two states. CLR_IDLE becomes CLR_PRIMED on a read that sees the flag at 1. CLR_PRIMED returns to CLR_IDLE on any write, or when the flag is 0.

Top module: `pcap_irq_top`

## Requirements
- R1: After reset, the register reads 0 in every field and the interrupt output is 0.
- R2: The register layout is fixed. Bit 0 is the start bit, bit 1 is the capture flag and bit 2 is the interrupt enable. The start bit and the enable read back the last value written.
- R3: While armed, a rise on the input followed by a fall sets the flag. The flag reads 1 no later than four clock cycles after the input falls.
- R4: A pulse that rises and falls while the start bit is 0 never sets the flag.
- R5: A fall that has no rise before it since arming is ignored. This includes a line that is already high when arming happens.
- R6: Writing the start bit to 0 discards a half-seen pulse. A fall after re-arming then needs a fresh rise.
- R7: A read that returns the flag as 1, followed by a write with bit 1 at 0, clears the flag.
- R8: A write with bit 1 at 0 that has no qualifying read before it leaves the flag unchanged. A write with bit 1 at 1 never changes the flag.
- R9: If a pulse completes in the same cycle as a valid clearing write, the flag stays 1.
- R10: The interrupt output is 1 exactly while the flag and the enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_i | input | 1 | Monitored asynchronous line |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Write data: bit 0 start, bit 1 flag, bit 2 enable |
| rd_data | output | 3 | Register read value, same layout |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is R9. A pulse must finish in exactly the same cycle as a primed clearing write. Only the synchroniser depth fixes when that cycle comes. The bench first primes the handshake with a read while the flag is already set and the line is held high. It then drops the line. Two falling clock edges later it issues the zero write, so the write and the completed pulse land on the same rising edge.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    localparam int unsigned REG_W     = 3;
    localparam int unsigned FLD_START = 0;
    localparam int unsigned FLD_FLAG  = 1;
    localparam int unsigned FLD_IEN   = 2;

    typedef enum logic [1:0] {
        TRK_OFF       = 2'd0,
        TRK_WAIT_RISE = 2'd1,
        TRK_WAIT_FALL = 2'd2
    } trk_state_e;

    typedef enum logic {
        CLR_IDLE   = 1'b0,
        CLR_PRIMED = 1'b1
    } clr_state_e;
endpackage

// File: rtl/pcap_sync.sv
module pcap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    always_comb begin
        level_o = chain_q[LAST];
        rise_o  =  chain_q[LAST] & ~prev_q;
        fall_o  = ~chain_q[LAST] &  prev_q;
    end
endmodule

// File: rtl/pcap_seq.sv
module pcap_seq
    import pcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_i,
    input  logic       rise_i,
    input  logic       fall_i,
    output logic       hit_o,
    output trk_state_e state_o
);
    trk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_OFF: begin
                if (arm_i) state_d = TRK_WAIT_RISE;
            end
            TRK_WAIT_RISE: begin
                if (!arm_i)      state_d = TRK_OFF;
                else if (rise_i) state_d = TRK_WAIT_FALL;
            end
            TRK_WAIT_FALL: begin
                if (!arm_i)      state_d = TRK_OFF;
                else if (fall_i) state_d = TRK_WAIT_RISE;
            end
            default: state_d = TRK_OFF;
        endcase
    end

    always_comb begin
        hit_o   = (state_q == TRK_WAIT_FALL) && fall_i && arm_i;
        state_o = state_q;
    end
endmodule

// File: rtl/pcap_flag.sv
module pcap_flag
    import pcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_flag_i,
    output logic flag_o,
    output logic primed_o
);
    clr_state_e clr_q, clr_d;
    logic       flag_q, flag_d;
    logic       clear_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q  <= CLR_IDLE;
            flag_q <= 1'b0;
        end else begin
            clr_q  <= clr_d;
            flag_q <= flag_d;
        end
    end

    always_comb begin
        clr_d = clr_q;
        unique case (clr_q)
            CLR_IDLE: begin
                if (!wr_i && rd_i && flag_q) clr_d = CLR_PRIMED;
            end
            CLR_PRIMED: begin
                if (wr_i || !flag_q) clr_d = CLR_IDLE;
            end
            default: clr_d = CLR_IDLE;
        endcase
    end

    always_comb begin
        clear_ok = wr_i && !wr_flag_i && (clr_q == CLR_PRIMED);
        if (set_i)         flag_d = 1'b1;
        else if (clear_ok) flag_d = 1'b0;
        else               flag_d = flag_q;
        flag_o   = flag_q;
        primed_o = (clr_q == CLR_PRIMED);
    end
endmodule

// File: rtl/pcap_irq_top.sv
module pcap_irq_top
    import pcap_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mon_i,
    input  logic                         rd_en,
    input  logic                         wr_en,
    input  logic [pcap_pkg::REG_W-1:0]   wr_data,
    output logic [pcap_pkg::REG_W-1:0]   rd_data,
    output logic                         irq_o
);
    logic       mon_lvl, mon_rise, mon_fall;
    logic       start_q, ien_q;
    logic       hit, flag_q, primed;
    trk_state_e trk_state;

    pcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (mon_i),
        .level_o (mon_lvl),
        .rise_o  (mon_rise),
        .fall_o  (mon_fall)
    );

    pcap_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (start_q),
        .rise_i  (mon_rise),
        .fall_i  (mon_fall),
        .hit_o   (hit),
        .state_o (trk_state)
    );

    pcap_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (hit),
        .rd_i      (rd_en),
        .wr_i      (wr_en),
        .wr_flag_i (wr_data[FLD_FLAG]),
        .flag_o    (flag_q),
        .primed_o  (primed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            ien_q   <= 1'b0;
        end else if (wr_en) begin
            start_q <= wr_data[FLD_START];
            ien_q   <= wr_data[FLD_IEN];
        end
    end

    always_comb begin
        rd_data            = '0;
        rd_data[FLD_START] = start_q;
        rd_data[FLD_FLAG]  = flag_q;
        rd_data[FLD_IEN]   = ien_q;
        irq_o              = flag_q & ien_q;
    end
endmodule

// File: rtl/pcap_irq_chk.sv
module pcap_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_data,
    input logic       start_q,
    input logic       ien_q,
    input logic       flag_q,
    input logic       primed,
    input logic       hit,
    input logic       mon_lvl,
    input logic       irq_o
);
    a_r3_hit_on_low_level: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !mon_lvl);

    a_r4_flag_rise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(start_q));

    a_r7_fall_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(wr_en && !wr_data[1] && primed));

    a_r8_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1] && flag_q) |=> flag_q);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ien_q && flag_q));
endmodule

bind pcap_irq_top pcap_irq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .start_q (start_q),
    .ien_q   (ien_q),
    .flag_q  (flag_q),
    .primed  (primed),
    .hit     (hit),
    .mon_lvl (mon_lvl),
    .irq_o   (irq_o)
);

// File: tb/pcap_irq_top_bench.sv
module pcap_irq_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_i = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = '0;
    logic [2:0] rd_data;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pcap_irq_top u_pcap_irq_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .mon_i   (mon_i),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_o   (irq_o)
    );

    // Vector: op[13:12] (0 line, 1 write, 2 read), wdata[11:9], line[8],
    // expected rd_data[7:5], expected irq[4], requirement number[3:0]
    localparam int NV = 20;
    localparam logic [13:0] VEC [NV] = '{
        {2'd1, 3'b000, 1'b0, 3'b000, 1'b0, 4'd2},  // R2 idle write
        {2'd0, 3'b000, 1'b1, 3'b000, 1'b0, 4'd4},  // R4 rise unarmed
        {2'd0, 3'b000, 1'b0, 3'b000, 1'b0, 4'd4},  // R4 fall unarmed
        {2'd0, 3'b000, 1'b1, 3'b000, 1'b0, 4'd4},  // line high
        {2'd1, 3'b001, 1'b1, 3'b001, 1'b0, 4'd2},  // R2 arm, start reads back
        {2'd0, 3'b000, 1'b0, 3'b001, 1'b0, 4'd5},  // R5 fall with no rise
        {2'd0, 3'b000, 1'b1, 3'b001, 1'b0, 4'd3},  // rise
        {2'd0, 3'b000, 1'b0, 3'b011, 1'b0, 4'd3},  // R3 capture
        {2'd1, 3'b110, 1'b0, 3'b110, 1'b1, 4'd8},  // R8 write 1 keeps, R10
        {2'd1, 3'b100, 1'b0, 3'b110, 1'b1, 4'd8},  // R8 zero without read
        {2'd2, 3'b000, 1'b0, 3'b110, 1'b1, 4'd7},  // read primes
        {2'd1, 3'b100, 1'b0, 3'b100, 1'b0, 4'd7},  // R7 clear
        {2'd1, 3'b101, 1'b0, 3'b101, 1'b0, 4'd6},  // arm
        {2'd0, 3'b000, 1'b1, 3'b101, 1'b0, 4'd6},  // rise
        {2'd1, 3'b100, 1'b1, 3'b100, 1'b0, 4'd6},  // disarm mid pulse
        {2'd1, 3'b101, 1'b1, 3'b101, 1'b0, 4'd6},  // re-arm while high
        {2'd0, 3'b000, 1'b0, 3'b101, 1'b0, 4'd6},  // R6 fall ignored
        {2'd0, 3'b000, 1'b1, 3'b101, 1'b0, 4'd3},  // fresh rise
        {2'd0, 3'b000, 1'b0, 3'b111, 1'b1, 4'd10}, // R3 capture, R10 irq
        {2'd1, 3'b000, 1'b0, 3'b010, 1'b0, 4'd10}  // R10 enable off
    };

    task automatic check(input int req, input logic [2:0] exp_rd, input logic exp_irq);
        n_cmp++;
        if (rd_data !== exp_rd || irq_o !== exp_irq) begin
            n_bad++;
            $display("FAIL R%0d: rd_data=%b irq=%b expected rd_data=%b irq=%b",
                     req, rd_data, irq_o, exp_rd, exp_irq);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, 3'b000, 1'b0);   // R1 values during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 3'b000, 1'b0);   // R1 after reset release

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            mon_i = VEC[v][8];
            if (VEC[v][13:12] == 2'd1) begin
                wr_en   = 1'b1;
                wr_data = VEC[v][11:9];
            end else if (VEC[v][13:12] == 2'd2) begin
                rd_en = 1'b1;
            end
            @(negedge clk);
            wr_en = 1'b0;
            rd_en = 1'b0;
            settle();
            check(int'(VEC[v][3:0]), VEC[v][7:5], VEC[v][4]);
        end

        // R9: flag 1, enable 1, armed, line high so the tracker waits for the fall
        @(negedge clk); wr_en = 1'b1; wr_data = 3'b101;
        @(negedge clk); wr_en = 1'b0; mon_i = 1'b1;
        settle();
        check(9, 3'b111, 1'b1);
        @(negedge clk); rd_en = 1'b1;               // primes the clear
        @(negedge clk); rd_en = 1'b0; mon_i = 1'b0; // line drops
        @(negedge clk);                              // first synchroniser stage
        @(negedge clk); wr_en = 1'b1; wr_data = 3'b101; // clear meets the capture
        @(negedge clk); wr_en = 1'b0;
        check(9, 3'b111, 1'b1);
        settle();
        check(9, 3'b111, 1'b1);

        // R7: a proper handshake now clears the flag
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; wr_en = 1'b1; wr_data = 3'b100;
        @(negedge clk); wr_en = 1'b0;
        check(7, 3'b100, 1'b0);

        // R4: a full pulse while disarmed leaves the flag at 0
        @(negedge clk); mon_i = 1'b1;
        settle();
        @(negedge clk); mon_i = 1'b0;
        settle();
        check(4, 3'b100, 1'b0);

        // R1: reset in the middle of operation restores zeros
        @(negedge clk); wr_en = 1'b1; wr_data = 3'b101;
        @(negedge clk); wr_en = 1'b0; mon_i = 1'b1;
        settle();
        @(negedge clk); mon_i = 1'b0;
        settle();
        check(3, 3'b111, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 3'b000, 1'b0);
        rst_n = 1'b1;
        settle();
        check(1, 3'b000, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule